// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block is a watchdog timer that software reaches through a small 32-bit register bus. An up-counter advances by one on each clock cycle in which the count tick is high and counting is enabled. Whenever the counter becomes equal to a programmed compare value, the block runs a set of timeout actions. Each action is enabled separately: latch an interrupt flag, clear the counter and disarm it, drive the compare pin, and start reset pulses whose width software programs. One pulse goes to the system reset request and one goes to an external reset output.

Software can also fire the reset pulses directly, without waiting for a compare. A reset-cause flag records that the watchdog produced a reset. Only the power-on reset input clears this flag, so firmware that boots afterwards can tell a watchdog reset from a cold start. A control bit lets a debug-halt input freeze the counter while a debugger holds the core. A clear request holds the counter at zero.

Top module: `match_watchdog`

## Requirements
- R1: After power-on reset (rstN low), every register reads zero, the counter is zero, and irq, sysRstReq, extRstReq and matchPin are low.
- R2: With control bit 0 (run) set, the counter (word 2, byte offset 0x08) increases by exactly one on each cycle in which tick is high. It holds its value on cycles where tick is low.
- R3: With control bit 2 set, the counter holds while dbgHalt is high. With control bit 2 clear, dbgHalt has no effect.
- R4: While control bit 1 is set, the counter reads zero from the cycle after the write and does not advance.
- R5: A compare event occurs once each time the enabled counter becomes equal to the compare value (word 4). This holds even when the counter then rests on that value. An event sets bit 0 of the status word (word 0). Writing 1 to that bit clears it. irq is high only while the flag and compare-control bit 0 (word 3) are both set.
- R6: With compare-control bit 2 set, a compare event clears the counter and clears control bit 0 on the next cycle.
- R7: With compare-control bit 3 set, a compare event drives sysRstReq high for (pulse width, word 6) + 6 cycles. extRstReq stays low.
- R8: With compare-control bit 4 set, a compare event drives both sysRstReq and extRstReq high for (pulse width) + 6 cycles.
- R9: Writing 1 to compare-control bit 5 starts the system pulse at once. Writing 1 to bit 6 starts both pulses at once. Bits 5, 6 and bit 1 always read as zero.
- R10: Pin-control word 5, bits 5:4, set the pin action on a compare event: 0 keep, 1 low, 2 high, 3 toggle. Bit 0 reads the pin, and a write loads the pin from it.
- R11: Bit 0 of the reset-status word (word 7) is set when either reset pulse starts. A bus write does not change it. Only rstN clears it.
- R12: Writes to the counter word are ignored. Unused bits, misaligned addresses and addresses at 0x20 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| tick | input | 1 | Count-enable tick |
| dbgHalt | input | 1 | Debugger halt request |
| busAddr | input | 6 | Byte address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when busRd is low |
| irq | output | 1 | Interrupt request |
| sysRstReq | output | 1 | System reset pulse |
| extRstReq | output | 1 | External reset pulse |
| matchPin | output | 1 | Compare output pin |

## Verification
The assertions check several properties on every cycle: the counter holds whenever no advance, clear or stop is commanded; a clear request zeroes it; each compare event lasts one cycle and sets the flag; a stop-on-compare event disarms the counter; a reset pulse never ends early; and the reset-cause flag never falls without rstN. Only the bench scenarios can show the rest. These are the exact pulse lengths for both reset routes, the pin action encodings in sequence, the interrupt mask, the result of write-one-to-clear followed by a counter resting on the compare value, and the return to zero of the reset-cause flag after a power-on reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    RG_INTSTAT = 3'd0,
    RG_CTRL    = 3'd1,
    RG_COUNT   = 3'd2,
    RG_MCTRL   = 3'd3,
    RG_MATCH   = 3'd4,
    RG_EXTCTL  = 3'd5,
    RG_PULSE   = 3'd6,
    RG_RSTSTAT = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pinAct_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armed;     // counter enabled (control bit 0)
    logic run;       // advance this cycle
    logic clear;     // hold counter at zero
    logic stopClr;   // stop-on-compare action
    logic startInt;  // start system reset pulse
    logic startExt;  // start external reset pulse
  } dpCmd_t;
endpackage

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PW_W  = 16,
  parameter int EXTRA = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [PW_W-1:0] width,
  output logic            active
);
  localparam int LEN_W = PW_W + 2;

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      remain <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        remain <= LEN_W'(width) + LEN_W'(EXTRA - 1);
      end
    end else if (remain == '0) begin
      active <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  // R7
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && remain != '0) |=> active);

  // R8
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && remain == '0) |=> !active);
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 16,
  parameter int EXTRA = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] matchVal,
  input  logic [PW_W-1:0]  pulseWidth,
  output logic [CNT_W-1:0] count,
  output logic             matchEvent,
  output logic             intRst,
  output logic             extRst
);
  localparam int NUM_PULSE = 2;

  logic eqNow, eqPrev;
  logic [NUM_PULSE-1:0] startVec, activeVec;

  assign eqNow      = (count == matchVal) && cmd.armed;
  assign matchEvent = eqNow && !eqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      eqPrev <= 1'b0;
    end else begin
      eqPrev <= eqNow;
      if (cmd.clear || cmd.stopClr) count <= '0;
      else if (cmd.run)            count <= count + 1'b1;
    end
  end

  assign startVec = {cmd.startExt, cmd.startInt};

  for (genvar g = 0; g < NUM_PULSE; g++) begin : gPulse
    wdog_pulse #(.PW_W(PW_W), .EXTRA(EXTRA)) uPulse (
      .clk   (clk),
      .rstN  (rstN),
      .start (startVec[g]),
      .width (pulseWidth),
      .active(activeVec[g])
    );
  end

  assign intRst = activeVec[0];
  assign extRst = activeVec[1];

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (count == '0));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.clear && !cmd.stopClr) |=> $stable(count));

  // R5
  single_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchEvent |=> !matchEvent);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PW_W   = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              dbgHalt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              matchEvent,
  output dpCmd_t            cmd,
  output logic [CNT_W-1:0]  matchVal,
  output logic [PW_W-1:0]   pulseWidth,
  output logic              irq,
  output logic              matchPin
);
  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + 2;

  logic    mapped;
  regSel_e regIdx;
  logic    ctrlEn, ctrlClr, ctrlDbg;
  logic    mcInt, mcStop, mcRst, mcRstExt;
  logic    intFlag, rstCause;
  pinAct_e extAct;
  logic    wrInt, wrCtrl, wrMctrl, wrMatch, wrExt, wrPulse;
  logic    forceInt, forceExt;
  logic [REG_W-1:0] rdMux;

  assign mapped = (busAddr[ADDR_W-1:IDX_MSB+1] == '0) && (busAddr[IDX_LSB-1:0] == '0);
  assign regIdx = regSel_e'(busAddr[IDX_MSB:IDX_LSB]);

  assign wrInt   = busWr && mapped && (regIdx == RG_INTSTAT);
  assign wrCtrl  = busWr && mapped && (regIdx == RG_CTRL);
  assign wrMctrl = busWr && mapped && (regIdx == RG_MCTRL);
  assign wrMatch = busWr && mapped && (regIdx == RG_MATCH);
  assign wrExt   = busWr && mapped && (regIdx == RG_EXTCTL);
  assign wrPulse = busWr && mapped && (regIdx == RG_PULSE);

  assign forceInt = wrMctrl && busWdata[5];
  assign forceExt = wrMctrl && busWdata[6];

  always_comb begin
    cmd          = '0;
    cmd.armed    = ctrlEn;
    cmd.clear    = ctrlClr;
    cmd.run      = ctrlEn && tick && !ctrlClr && !(ctrlDbg && dbgHalt);
    cmd.stopClr  = matchEvent && mcStop;
    cmd.startInt = (matchEvent && (mcRst || mcRstExt)) || forceInt || forceExt;
    cmd.startExt = (matchEvent && mcRstExt) || forceExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn     <= 1'b0;
      ctrlClr    <= 1'b0;
      ctrlDbg    <= 1'b0;
      mcInt      <= 1'b0;
      mcStop     <= 1'b0;
      mcRst      <= 1'b0;
      mcRstExt   <= 1'b0;
      matchVal   <= '0;
      pulseWidth <= '0;
      extAct     <= PIN_KEEP;
      matchPin   <= 1'b0;
      intFlag    <= 1'b0;
      rstCause   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ctrlEn  <= busWdata[0];
        ctrlClr <= busWdata[1];
        ctrlDbg <= busWdata[2];
      end
      if (cmd.stopClr) ctrlEn <= 1'b0;
      if (wrMctrl) begin
        mcInt    <= busWdata[0];
        mcStop   <= busWdata[2];
        mcRst    <= busWdata[3];
        mcRstExt <= busWdata[4];
      end
      if (wrMatch) matchVal   <= busWdata[CNT_W-1:0];
      if (wrPulse) pulseWidth <= busWdata[PW_W-1:0];
      if (wrExt) begin
        extAct   <= pinAct_e'(busWdata[5:4]);
        matchPin <= busWdata[0];
      end
      if (matchEvent) begin
        case (extAct)
          PIN_LOW:    matchPin <= 1'b0;
          PIN_HIGH:   matchPin <= 1'b1;
          PIN_TOGGLE: matchPin <= ~matchPin;
          default:    ;
        endcase
      end
      if (wrInt && busWdata[0]) intFlag <= 1'b0;
      if (matchEvent)           intFlag <= 1'b1;
      if (cmd.startInt || cmd.startExt) rstCause <= 1'b1;
    end
  end

  assign irq = intFlag && mcInt;

  always_comb begin
    rdMux = '0;
    case (regIdx)
      RG_INTSTAT: rdMux[0] = intFlag;
      RG_CTRL:    rdMux[2:0] = {ctrlDbg, ctrlClr, ctrlEn};
      RG_COUNT:   rdMux = REG_W'(count);
      RG_MCTRL:   rdMux[4:0] = {mcRstExt, mcRst, mcStop, 1'b0, mcInt};
      RG_MATCH:   rdMux = REG_W'(matchVal);
      RG_EXTCTL:  begin rdMux[5:4] = extAct; rdMux[0] = matchPin; end
      RG_PULSE:   rdMux = REG_W'(pulseWidth);
      RG_RSTSTAT: rdMux[0] = rstCause;
      default:    rdMux = '0;
    endcase
  end

  assign busRdata = (busRd && mapped) ? rdMux : '0;

  // R11
  sticky_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstCause |=> rstCause);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchEvent |=> intFlag);

  // R6
  stop_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvent && mcStop) |=> !ctrlEn);
endmodule

// File: rtl/match_watchdog.sv
module match_watchdog
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PW_W   = 16,
  parameter int EXTRA  = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              dbgHalt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              sysRstReq,
  output logic              extRstReq,
  output logic              matchPin
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] count, matchVal;
  logic [PW_W-1:0]  pulseWidth;
  logic             matchEvent;

  wdog_regs #(.CNT_W(CNT_W), .PW_W(PW_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .tick(tick), .dbgHalt(dbgHalt),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata),
    .count(count), .matchEvent(matchEvent), .cmd(cmd),
    .matchVal(matchVal), .pulseWidth(pulseWidth),
    .irq(irq), .matchPin(matchPin)
  );

  wdog_datapath #(.CNT_W(CNT_W), .PW_W(PW_W), .EXTRA(EXTRA)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .matchVal(matchVal),
    .pulseWidth(pulseWidth), .count(count), .matchEvent(matchEvent),
    .intRst(sysRstReq), .extRst(extRstReq)
  );
endmodule

// File: tb/tb_match_watchdog.sv
module tb_match_watchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic        dbgHalt = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, sysRstReq, extRstReq, matchPin;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  localparam logic [5:0] A_INT = 6'h00, A_CTRL = 6'h04, A_CNT = 6'h08, A_MC = 6'h0C,
                         A_MATCH = 6'h10, A_EXT = 6'h14, A_PW = 6'h18, A_RST = 6'h1C;

  match_watchdog dut (
    .clk(clk), .rstN(rstN), .tick(tick), .dbgHalt(dbgHalt),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq), .sysRstReq(sysRstReq),
    .extRstReq(extRstReq), .matchPin(matchPin)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    #1;
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic countHigh(input int window, output int nInt, output int nExt);
    nInt = 0; nExt = 0;
    for (int i = 0; i < window; i++) begin
      if (sysRstReq) nInt++;
      if (extRstReq) nExt++;
      @(negedge clk);
    end
  endtask

  task automatic clearCounter();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic tReset();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(6'(i * 4), d);
      chk("R1 reg after reset", d, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 sysRstReq", sysRstReq, 0);
    chk("R1 extRstReq", extRstReq, 0);
    chk("R1 matchPin", matchPin, 0);
  endtask

  task automatic tCount();
    logic [31:0] a, b;
    clearCounter();
    rd(A_CNT, a);
    chk("R4 counter zero after clear", a, 0);
    wr(A_CTRL, 32'h1);
    rd(A_CNT, a); waitCyc(10); rd(A_CNT, b);
    chk("R2 advance by 10", b - a, 10);
    tick = 1'b0;
    rd(A_CNT, a); waitCyc(5); rd(A_CNT, b);
    chk("R2 hold when tick low", b - a, 0);
    tick = 1'b1;
  endtask

  task automatic tClear();
    logic [31:0] a;
    wr(A_CTRL, 32'h3);
    waitCyc(1);
    rd(A_CNT, a);
    chk("R4 cleared", a, 0);
    waitCyc(5);
    rd(A_CNT, a);
    chk("R4 stays zero", a, 0);
  endtask

  task automatic tDebug();
    logic [31:0] a, b;
    clearCounter();
    wr(A_CTRL, 32'h5);
    dbgHalt = 1'b1;
    rd(A_CNT, a); waitCyc(8); rd(A_CNT, b);
    chk("R3 halted by debug", b - a, 0);
    wr(A_CTRL, 32'h1);
    rd(A_CNT, a); waitCyc(8); rd(A_CNT, b);
    chk("R3 debug ignored when gate off", b - a, 8);
    dbgHalt = 1'b0;
    wr(A_CTRL, 32'h0);
  endtask

  task automatic tMatchOnce();
    logic [31:0] d;
    tick = 1'b0;
    clearCounter();
    wr(A_MATCH, 32'd5);
    wr(A_MC, 32'h1);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    waitCyc(1);
    rd(A_INT, d);
    chk("R5 flag set on compare", d, 1);
    chk("R5 irq enabled", irq, 1);
    wr(A_INT, 32'h1);
    waitCyc(4);
    rd(A_INT, d);
    chk("R5 no refire while resting on compare", d, 0);
    chk("R5 irq low after clear", irq, 0);
    tick = 1'b1;
    wr(A_CTRL, 32'h0);
    wr(A_MC, 32'h0);
  endtask

  task automatic tStop();
    logic [31:0] d;
    clearCounter();
    wr(A_MATCH, 32'd10);
    wr(A_MC, 32'h4);
    wr(A_CTRL, 32'h1);
    waitCyc(25);
    rd(A_CTRL, d);
    chk("R6 run bit cleared", d, 0);
    rd(A_CNT, d);
    chk("R6 counter cleared", d, 0);
    wr(A_INT, 32'h1);
  endtask

  task automatic tResetPulses();
    int ni, ne;
    logic [31:0] d;
    clearCounter();
    wr(A_MATCH, 32'd12);
    wr(A_PW, 32'd3);
    wr(A_MC, 32'h8);
    wr(A_CTRL, 32'h1);
    countHigh(60, ni, ne);
    chk("R7 system pulse length", ni, 9);
    chk("R7 external stays low", ne, 0);
    chk("R5 irq masked", irq, 0);
    rd(A_RST, d);
    chk("R11 cause set", d, 1);
    clearCounter();
    wr(A_PW, 32'd5);
    wr(A_MC, 32'h10);
    wr(A_CTRL, 32'h1);
    countHigh(60, ni, ne);
    chk("R8 system pulse length", ni, 11);
    chk("R8 external pulse length", ne, 11);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic tForce();
    int ni, ne;
    logic [31:0] d;
    wr(A_PW, 32'd2);
    wr(A_MC, 32'h40);
    countHigh(30, ni, ne);
    chk("R9 forced both, system", ni, 8);
    chk("R9 forced both, external", ne, 8);
    rd(A_MC, d);
    chk("R9 force bits read zero", d, 0);
    wr(A_MC, 32'h22);
    countHigh(30, ni, ne);
    chk("R9 forced system only", ni, 8);
    chk("R9 forced system, external low", ne, 0);
    rd(A_MC, d);
    chk("R9 bit1 and bit5 read zero", d, 0);
    wr(A_MC, 32'h0);
  endtask

  task automatic tPin();
    logic [31:0] d;
    clearCounter();
    wr(A_MATCH, 32'd6);
    wr(A_EXT, 32'h20);
    wr(A_CTRL, 32'h1);
    waitCyc(20);
    chk("R10 drive high", matchPin, 1);
    rd(A_EXT, d);
    chk("R10 readback", d, 32'h21);
    wr(A_EXT, 32'h31);
    clearCounter();
    wr(A_CTRL, 32'h1);
    waitCyc(20);
    chk("R10 toggle", matchPin, 0);
    wr(A_EXT, 32'h11);
    chk("R10 direct write", matchPin, 1);
    clearCounter();
    wr(A_CTRL, 32'h1);
    waitCyc(20);
    chk("R10 drive low", matchPin, 0);
    wr(A_CTRL, 32'h0);
    wr(A_EXT, 32'h0);
  endtask

  task automatic tMisc();
    logic [31:0] a, b;
    rd(A_RST, a);
    chk("R11 cause still set", a, 1);
    wr(A_RST, 32'h0);
    rd(A_RST, a);
    chk("R11 write ignored", a, 1);
    rd(A_CNT, a);
    wr(A_CNT, 32'h0000ABC0);
    rd(A_CNT, b);
    chk("R12 counter write ignored", b, a);
    rd(6'h24, a);
    chk("R12 unmapped reads zero", a, 0);
    rd(6'h15, a);
    chk("R12 misaligned reads zero", a, 0);
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, a);
    chk("R12 reserved ctrl bits zero", a, 0);
    @(negedge clk); rstN = 1'b0;
    waitCyc(2); rstN = 1'b1;
    rd(A_RST, a);
    chk("R11 cleared by power-on reset", a, 0);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    tReset();
    tCount();
    tClear();
    tDebug();
    tMatchOnce();
    tStop();
    tResetPulses();
    tForce();
    tPin();
    tMisc();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule